// File: doc/BRIEF.md
# Selectable CRC Error Event Counter

This block is a small byte-addressed register bank that holds one saturating event counter for each of two CRC error classes: link-layer CRC errors and end-to-end CRC errors. A simple memory-mapped slave port with a 21-bit address and 8-bit data lets software arm CRC checking, pick an error class with a group/event code pair, enable counting, and clear one counter or both. Two single-cycle pulse inputs report error events of each class. The count of the currently selected class is read back as four byte-wide registers, least significant byte first.

The control register block sits at a base address that depends on the link-width parameter (x16, x8 or x4). The CRC-check enable sits at one fixed address for every width. Reads are registered: data and a valid strobe appear one cycle after the read request. Only the counter that the current code pair selects can increment.

Top module: `crc_evt_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration field and both counters are zero, `bus_rdata` is 0x00 and `bus_rvalid` is low.
- R2: The CRC-check enable is bit 0 of the register at address 0x119 for every link width. It reads back as that bit, with bits [7:1] reading 0.
- R3: The control byte sits at a base address of 0x33C (x16), 0x304 (x8) or 0x2B0 (x4). Lane select is at base+1, event number at base+2 and group number at base+3, and all three read back the full 8 bits written.
- R4: Control bits [4:2] hold the counter enable and read back as written. Control bits [1:0] and [7:5] always read 0.
- R5: With group 0x02 and event 0x01 selected, CRC check on and control bits [4:2] = 3'b111, the link-error counter rises by one for each cycle in which `lcrc_err` is high. `ecrc_err` has no effect on it.
- R6: With group 0x03 and event 0x02 selected under the same enables, the end-to-end counter rises by one for each cycle in which `ecrc_err` is high. The other counter keeps its value.
- R7: No counter changes while CRC check is off, while control bits [4:2] are not all ones, or while the group/event pair matches neither class.
- R8: Count bytes at base+4 through base+7 return bits [7:0], [15:8], [23:16] and [31:24] of the selected counter, zero-extended from CNT_W bits. With no valid selection they read 0x00.
- R9: A write of the control byte with bits [1:0] = 2'b01 clears only the selected counter. With bits [1:0] = 2'b11 it clears both counters. 2'b00 and 2'b10 clear nothing.
- R10: When a clear and an increment of the same counter fall in the same cycle, the counter ends at zero.
- R11: A counter saturates at its all-ones value (2^CNT_W - 1) and does not wrap.
- R12: Reads of unmapped addresses return 0x00. Writes to unmapped addresses and to the count bytes change no register.
- R13: `bus_rvalid` is high exactly in the cycle after a read request. `bus_rdata` keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request for one cycle |
| bus_rd | input | 1 | Read request for one cycle |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle after a read request |
| lcrc_err | input | 1 | Link-layer CRC error event, one per high cycle |
| ecrc_err | input | 1 | End-to-end CRC error event, one per high cycle |

## Verification
An internal fault shows up as a wrong byte on `bus_rdata` in the cycle after the first read of the affected register. The only exception is a counter fault that stays hidden until software selects that class. A selection or enable decode that is wrong shows up as a count that differs after a single error pulse. A clear or saturation fault needs a read after the clearing write, or after the counter has been driven to its limit. For that reason the bench uses a narrow counter, so that saturation can be reached within the run, and it reads every count byte after each directed step.

// File: rtl/crc_evt_pkg.sv
// Shared constants, types and address helpers for the CRC error event counter.
// Assumes byte-wide registers and two error classes (index 0 link, 1 end-to-end).
package crc_evt_pkg;

    localparam int BYTE_W      = 8;
    localparam int NUM_CLASSES = 2;
    localparam int VIEW_W      = 32;
    localparam int VIEW_BYTES  = VIEW_W / BYTE_W;

    localparam int CLS_LINK = 0;
    localparam int CLS_E2E  = 1;

    localparam logic [20:0] CRC_ENABLE_OFS = 21'h00119;

    // Base of the control block for a given link width.
    function automatic logic [20:0] ctrl_base(input int link_width);
        case (link_width)
            16:      return 21'h0033C;
            8:       return 21'h00304;
            default: return 21'h002B0;
        endcase
    endfunction

    // Group code that selects a class.
    function automatic logic [BYTE_W-1:0] class_group(input int cls);
        return (cls == CLS_LINK) ? 8'h02 : 8'h03;
    endfunction

    // Event code that selects a class.
    function automatic logic [BYTE_W-1:0] class_event(input int cls);
        return (cls == CLS_LINK) ? 8'h01 : 8'h02;
    endfunction

    typedef struct packed {
        logic              crc_on;
        logic [2:0]        cnt_en;
        logic [BYTE_W-1:0] lane;
        logic [BYTE_W-1:0] evt;
        logic [BYTE_W-1:0] grp;
    } cfg_t;

    typedef enum logic [1:0] {
        CLR_NONE   = 2'b00,
        CLR_SEL    = 2'b01,
        CLR_RSVD   = 2'b10,
        CLR_ALL    = 2'b11
    } clr_code_e;

endpackage

// File: rtl/crc_evt_regfile.sv
// Configuration registers and write decode.
// Holds the CRC enable, counter enable, lane, event and group fields, decodes the
// class selection from the group/event pair, and turns control writes into
// one-cycle clear requests. Assumes one access address per cycle.
module crc_evt_regfile
    import crc_evt_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int LINK_WIDTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BYTE_W-1:0]       bus_wdata,
    output cfg_t                    cfg,
    output logic [NUM_CLASSES-1:0]  sel_hot,
    output logic [NUM_CLASSES-1:0]  clr_req
);

    localparam logic [ADDR_W-1:0] A_CRC  = ADDR_W'(CRC_ENABLE_OFS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_base(LINK_WIDTH));
    localparam logic [ADDR_W-1:0] A_LANE = A_CTRL + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_EVT  = A_CTRL + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_GRP  = A_CTRL + ADDR_W'(3);

    logic      ctrl_wr;
    clr_code_e clr_code;

    // Register writes to the mapped configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CRC:   cfg.crc_on <= bus_wdata[0];
                A_CTRL:  cfg.cnt_en <= bus_wdata[4:2];
                A_LANE:  cfg.lane   <= bus_wdata;
                A_EVT:   cfg.evt    <= bus_wdata;
                A_GRP:   cfg.grp    <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Class selection: one bit per class whose code pair matches.
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_sel
        assign sel_hot[c] = (cfg.grp == class_group(c)) && (cfg.evt == class_event(c));
    end

    assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    assign clr_code = clr_code_e'(bus_wdata[1:0]);

    // Clear requests from a control write: selected class or every class.
    always_comb begin
        clr_req = '0;
        if (ctrl_wr) begin
            case (clr_code)
                CLR_SEL: clr_req = sel_hot;
                CLR_ALL: clr_req = '1;
                default: clr_req = '0;
            endcase
        end
    end

    AST_CFG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cfg)); // R12

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_hot)); // R7

    AST_CLR_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_req) |-> (bus_wr && bus_addr == A_CTRL)); // R9

endmodule

// File: rtl/crc_evt_counter.sv
// One saturating event counter.
// Clears on clr (which has priority), otherwise adds one on inc until all ones.
// Assumes clr and inc are single-cycle qualified strobes.
module crc_evt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;

    assign at_max = (count == CNT_MAX);

    // Count update: clear wins, increment stops at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && !at_max) begin
            count <= count + CNT_W'(1);
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R10

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == CNT_MAX) |=> (count == CNT_MAX)); // R11

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && count != CNT_MAX) |=> (count == $past(count) + CNT_W'(1))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count)); // R7

endmodule

// File: rtl/crc_evt_readport.sv
// Registered read port.
// Returns the configuration fields or one byte of the selected counter, zero for
// unmapped addresses, one cycle after the read request. Assumes CNT_W <= 32.
module crc_evt_readport
    import crc_evt_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int LINK_WIDTH = 16,
    parameter int CNT_W      = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_rd,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  cfg_t                               cfg,
    input  logic [NUM_CLASSES-1:0]             sel_hot,
    input  logic [NUM_CLASSES-1:0][CNT_W-1:0]  counts,
    output logic [BYTE_W-1:0]                  bus_rdata,
    output logic                               bus_rvalid
);

    localparam logic [ADDR_W-1:0] A_CRC  = ADDR_W'(CRC_ENABLE_OFS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_base(LINK_WIDTH));
    localparam logic [ADDR_W-1:0] A_CNT0 = A_CTRL + ADDR_W'(4);

    logic [VIEW_W-1:0] view;
    logic [BYTE_W-1:0] rd_byte;

    // Count of the selected class, zero-extended; zero with no selection.
    always_comb begin
        view = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (sel_hot[c]) begin
                view = view | VIEW_W'(counts[c]);
            end
        end
    end

    // Address decode of the readable bytes.
    always_comb begin
        rd_byte = '0;
        if (bus_addr == A_CRC) begin
            rd_byte = {7'b0, cfg.crc_on};
        end else if (bus_addr == A_CTRL) begin
            rd_byte = {3'b0, cfg.cnt_en, 2'b00};
        end else if (bus_addr == A_CTRL + ADDR_W'(1)) begin
            rd_byte = cfg.lane;
        end else if (bus_addr == A_CTRL + ADDR_W'(2)) begin
            rd_byte = cfg.evt;
        end else if (bus_addr == A_CTRL + ADDR_W'(3)) begin
            rd_byte = cfg.grp;
        end else begin
            for (int b = 0; b < VIEW_BYTES; b++) begin
                if (bus_addr == A_CNT0 + ADDR_W'(b)) begin
                    rd_byte = view[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Read data register: loads only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_byte;
        end
    end

    // Read valid strobe, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
        end
    end

    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R13

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R13

endmodule

// File: rtl/crc_evt_counter_bank.sv
// Top of the selectable CRC error event counter.
// Wires the register file, one saturating counter per error class and the read
// port. A class counts only when CRC check is on, all enable bits are set and
// its group/event pair is selected. Assumes LINK_WIDTH of 16, 8 or 4 (other
// values take the x4 map) and CNT_W between 1 and 32.
module crc_evt_counter_bank
    import crc_evt_pkg::*;
#(
    parameter int LINK_WIDTH = 16,
    parameter int ADDR_W     = 21,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    input  logic              lcrc_err,
    input  logic              ecrc_err
);

    cfg_t                              cfg;
    logic [NUM_CLASSES-1:0]            sel_hot;
    logic [NUM_CLASSES-1:0]            clr_req;
    logic [NUM_CLASSES-1:0]            evt_in;
    logic [NUM_CLASSES-1:0]            inc;
    logic [NUM_CLASSES-1:0][CNT_W-1:0] counts;
    logic                              armed;

    crc_evt_regfile #(
        .ADDR_W     (ADDR_W),
        .LINK_WIDTH (LINK_WIDTH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg       (cfg),
        .sel_hot   (sel_hot),
        .clr_req   (clr_req)
    );

    assign evt_in[CLS_LINK] = lcrc_err;
    assign evt_in[CLS_E2E]  = ecrc_err;
    assign armed            = cfg.crc_on && (&cfg.cnt_en);

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cnt
        assign inc[c] = armed && sel_hot[c] && evt_in[c];

        crc_evt_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_req[c]),
            .inc   (inc[c]),
            .count (counts[c])
        );
    end

    crc_evt_readport #(
        .ADDR_W     (ADDR_W),
        .LINK_WIDTH (LINK_WIDTH),
        .CNT_W      (CNT_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .cfg        (cfg),
        .sel_hot    (sel_hot),
        .counts     (counts),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_hot[CLS_E2E] && !clr_req[CLS_E2E]) |=> $stable(counts[CLS_E2E])); // R6

    AST_DISARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && clr_req == '0) |=> $stable(counts)); // R7

endmodule

// File: tb/crc_evt_counter_bank_tb.sv
// Bench: directed corner cases plus seeded random traffic against a cycle model.
module crc_evt_counter_bank_tb;

    localparam int CLK_P = 10;
    localparam int LW    = 8;
    localparam int AW    = 21;
    localparam int CW    = 12;
    localparam int MAXC  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_rvalid;
    logic          lcrc_err = 1'b0;
    logic          ecrc_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state.
    bit       m_crc;
    bit [2:0] m_en;
    bit [7:0] m_lane, m_evt, m_grp;
    int       m_cnt [2];

    always #(CLK_P/2) clk = ~clk;

    crc_evt_counter_bank #(
        .LINK_WIDTH (LW),
        .ADDR_W     (AW),
        .CNT_W      (CW)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .lcrc_err   (lcrc_err),
        .ecrc_err   (ecrc_err)
    );

    function automatic logic [AW-1:0] base_of(input int w);
        if (w == 16) return 21'h33C;
        if (w == 8)  return 21'h304;
        return 21'h2B0;
    endfunction

    localparam logic [AW-1:0] CRCA = 21'h119;
    logic [AW-1:0] B;

    function automatic int sel_of();
        if (m_grp == 8'h02 && m_evt == 8'h01) return 0;
        if (m_grp == 8'h03 && m_evt == 8'h02) return 1;
        return -1;
    endfunction

    function automatic logic [7:0] model_read(input logic [AW-1:0] a);
        int s;
        s = sel_of();
        if (a == CRCA)  return {7'b0, m_crc};
        if (a == B)     return {3'b0, m_en, 2'b00};
        if (a == B + 1) return m_lane;
        if (a == B + 2) return m_evt;
        if (a == B + 3) return m_grp;
        for (int k = 0; k < 4; k++) begin
            if (a == B + 4 + k) begin
                if (s < 0) return 8'h00;
                return 8'((m_cnt[s] >> (8*k)) & 32'hFF);
            end
        end
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One clock cycle with model update; compares reads with the model.
    task automatic cyc(input bit wr, input bit rd, input logic [AW-1:0] a,
                       input logic [7:0] d, input bit lp, input bit ep,
                       input string req);
        logic [7:0] exp_rd;
        bit clr [2];
        bit pulse [2];
        int s;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        lcrc_err = lp; ecrc_err = ep;
        exp_rd = model_read(a);
        s = sel_of();
        pulse[0] = lp; pulse[1] = ep;
        clr[0] = 0; clr[1] = 0;
        if (wr && a == B) begin
            if (d[1:0] == 2'b11) begin clr[0] = 1; clr[1] = 1; end
            else if (d[1:0] == 2'b01 && s >= 0) clr[s] = 1;
        end
        for (int c = 0; c < 2; c++) begin
            if (clr[c]) m_cnt[c] = 0;
            else if (m_crc && m_en == 3'b111 && s == c && pulse[c] && m_cnt[c] < MAXC)
                m_cnt[c]++;
        end
        if (wr) begin
            if (a == CRCA)       m_crc  = d[0];
            else if (a == B)     m_en   = d[4:2];
            else if (a == B + 1) m_lane = d;
            else if (a == B + 2) m_evt  = d;
            else if (a == B + 3) m_grp  = d;
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; lcrc_err = 0; ecrc_err = 0;
        if (rd) begin
            check({req, " rvalid"}, {7'b0, bus_rvalid}, 8'h01);
            check(req, bus_rdata, exp_rd);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        cyc(1, 0, a, d, 0, 0, "");
    endtask

    // Read with an explicit expected value, worked out from the requirement.
    task automatic rd_exp(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        cyc(0, 1, a, 8'h00, 0, 0, req);
        check({req, " explicit"}, bus_rdata, exp);
    endtask

    task automatic pulses(input int n, input bit lp, input bit ep);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 8'h00, lp, ep, "");
    endtask

    task automatic rd_count(input int exp, input string req);
        for (int k = 0; k < 4; k++) rd_exp(B + 4 + k, 8'((exp >> (8*k)) & 255), req);
    endtask

    // Watchdog.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        B = base_of(LW);
        seed = $urandom(32'h5EED1234);
        m_crc = 0; m_en = 0; m_lane = 0; m_evt = 0; m_grp = 0;
        m_cnt[0] = 0; m_cnt[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 rvalid", {7'b0, bus_rvalid}, 8'h00);
        rst_n = 1;
        rd_exp(CRCA, 8'h00, "R1");
        for (int k = 0; k < 8; k++) rd_exp(B + k, 8'h00, "R1");

        // R13: no read -> rvalid low, data held.
        cyc(0, 0, B, 8'h00, 0, 0, "");
        check("R13 rvalid idle", {7'b0, bus_rvalid}, 8'h00);

        // R2
        wr(CRCA, 8'hFF);
        rd_exp(CRCA, 8'h01, "R2");
        wr(CRCA, 8'h00);
        rd_exp(CRCA, 8'h00, "R2");

        // R3 / R4
        wr(B + 1, 8'hA5); wr(B + 2, 8'h5A); wr(B + 3, 8'h3C);
        rd_exp(B + 1, 8'hA5, "R3");
        rd_exp(B + 2, 8'h5A, "R3");
        rd_exp(B + 3, 8'h3C, "R3");
        wr(B, 8'hFC);
        rd_exp(B, 8'h1C, "R4");
        cyc(0, 0, CRCA, 8'h00, 0, 0, "");
        check("R13 rdata holds", bus_rdata, 8'h1C);

        // R5: link class counting.
        wr(B + 1, 8'h00); wr(B + 3, 8'h02); wr(B + 2, 8'h01); wr(CRCA, 8'h01);
        pulses(5, 1, 0);
        pulses(3, 0, 1);
        rd_count(5, "R5");
        rd_exp(B + 4, 8'h05, "R8");

        // R7: disarmed or partial enable.
        wr(CRCA, 8'h00);
        pulses(4, 1, 1);
        rd_exp(B + 4, 8'h05, "R7 crc off");
        wr(CRCA, 8'h01); wr(B, 8'h0C);
        pulses(4, 1, 1);
        rd_exp(B + 4, 8'h05, "R7 partial enable");
        wr(B, 8'h1C);

        // R6: end-to-end class.
        wr(B + 3, 8'h03); wr(B + 2, 8'h02);
        pulses(7, 0, 1);
        pulses(2, 1, 0);
        rd_count(7, "R6");
        wr(B + 2, 8'h01);
        rd_exp(B + 4, 8'h00, "R8 no selection");
        pulses(3, 1, 1);
        wr(B + 2, 8'h02);
        rd_exp(B + 4, 8'h07, "R7 invalid pair");
        wr(B + 3, 8'h02); wr(B + 2, 8'h01);
        rd_exp(B + 4, 8'h05, "R6 other kept");

        // R9: selected clear, then clear-all; reserved code clears nothing.
        wr(B, 8'h1E);
        rd_exp(B + 4, 8'h05, "R9 code 10");
        wr(B, 8'h1D);
        rd_exp(B + 4, 8'h00, "R9 clear selected");
        wr(B + 3, 8'h03); wr(B + 2, 8'h02);
        rd_exp(B + 4, 8'h07, "R9 other kept");
        wr(B, 8'h1F);
        rd_exp(B + 4, 8'h00, "R9 clear all");
        wr(B + 3, 8'h02); wr(B + 2, 8'h01);
        pulses(2, 1, 0);

        // R10: clear with a simultaneous increment.
        cyc(1, 0, B, 8'h1D, 1, 0, "");
        rd_count(0, "R10");

        // R11: saturation.
        pulses(MAXC + 5, 1, 0);
        rd_count(MAXC, "R11");
        pulses(3, 1, 0);
        rd_exp(B + 4, 8'hFF, "R11 held");

        // R12: unmapped and read-only addresses.
        wr(B - 1, 8'hFF); wr(B + 8, 8'hFF); wr(21'h118, 8'hFF); wr(21'h11A, 8'hFF);
        wr(B + 4, 8'h00); wr(21'h1FFFFF, 8'hFF);
        rd_exp(B - 1, 8'h00, "R12");
        rd_exp(B + 8, 8'h00, "R12");
        rd_exp(21'h1FFFFF, 8'h00, "R12");
        rd_exp(B + 4, 8'hFF, "R12 count read-only");
        rd_exp(B, 8'h1C, "R12 ctrl kept");
        rd_exp(B + 1, 8'h00, "R12 lane kept");
        rd_exp(B + 3, 8'h02, "R12 group kept");
        rd_exp(CRCA, 8'h01, "R12 enable kept");
        wr(B, 8'h1F);

        // Random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            int pick;
            logic [AW-1:0] a;
            logic [7:0] d;
            pick = $urandom_range(0, 9);
            a = (pick < 8) ? B + AW'(pick) : ((pick == 8) ? CRCA : AW'($urandom_range(0, 2047)));
            d = 8'($urandom);
            if (a == B && $urandom_range(0, 3) != 0) d = {3'b000, 3'b111, 2'($urandom_range(0, 3) == 0 ? 2'b01 : 2'b00)};
            if (a == B + 2 && $urandom_range(0, 3) != 0) d = 8'($urandom_range(1, 2));
            if (a == B + 3 && $urandom_range(0, 3) != 0) d = 8'($urandom_range(2, 3));
            if (a == CRCA && $urandom_range(0, 3) != 0) d = 8'h01;
            cyc(($urandom_range(0, 5) == 0), ($urandom_range(0, 2) == 0), a, d,
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R5 R6 R9 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule